// File: doc/BRIEF.md
# Cache-Line Wake Monitor

This block lets one processor core park itself until a particular cache line is written by someone else. The core first issues an arm command carrying the virtual address it wants to watch. It then issues a wait request carrying the already translated physical address. If no wakeup has been latched, the block trims that address down to its line boundary, records the line, enters the waiting state and answers "sleep". If a wakeup is already pending, the block consumes it and answers "do not sleep". In that case the core carries on at once.

The memory system presents invalidation addresses on a snoop stream. When the block is armed and waiting, a snoop whose address equals the recorded line exactly ends the wait and produces a one-cycle wake pulse. Within a single cycle the work is done in a fixed order: the arm command first, then the wait request, then the snoop comparison against whatever line the earlier steps left behind.

The wait and snoop inputs are valid/ready streams. The block never applies back-pressure, so both ready outputs are always high and every valid beat is taken in the cycle it is presented. Arm, wake and the state outputs are plain pins.

Top module: `line_wake_monitor`

## Requirements
- R1: After reset, armed, waiting, wake and rsp_valid are 0, and a wait request returns sleep (rsp_sleep=1) because no wakeup is pending.
- R2: An arm command sets armed, stores arm_vaddr in watch_vaddr and sets watch_line to zero, all visible on the cycle after the command.
- R3: A wait request with no pending wakeup stores wait_paddr with its low log2(LINE_BYTES) bits cleared in watch_line (bits 5:0 with the default 64-byte line) and sets waiting. One cycle later it gives rsp_valid=1 with rsp_sleep=1. Both ready outputs are always 1.
- R4: A wait request with a pending wakeup clears the pending wakeup, gives rsp_valid=1 with rsp_sleep=0 one cycle later, and does not set waiting.
- R5: A snoop whose address equals watch_line while armed and waiting clears waiting and drives wake high for exactly one cycle, on the cycle after the snoop. When no wait request arrives in that same cycle, no pending wakeup is left behind.
- R6: A snoop produces no wake when the block is not armed, or not waiting, or when the snoop address differs from watch_line in any bit, including a differing offset inside the same line.
- R7: When a wait request and a snoop arrive in the same cycle, the snoop is compared against the newly stored line. A hit clears waiting, pulses wake and leaves a pending wakeup, so the next wait request returns rsp_sleep=0.
- R8: After a wake, armed stays 1 and watch_vaddr is unchanged. Only a new arm command or reset changes the watched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arm_valid | input | 1 | Arm command strobe |
| arm_vaddr | input | ADDR_W | Virtual address to watch |
| wait_valid | input | 1 | Wait request valid |
| wait_ready | output | 1 | Wait request ready (always 1) |
| wait_paddr | input | ADDR_W | Translated physical address of the wait |
| rsp_valid | output | 1 | Wait response valid, one cycle after the request |
| rsp_sleep | output | 1 | 1 = core should sleep, 0 = return immediately |
| snoop_valid | input | 1 | Invalidation beat valid |
| snoop_ready | output | 1 | Invalidation ready (always 1) |
| snoop_paddr | input | ADDR_W | Invalidated physical line address |
| wake | output | 1 | One-cycle wake pulse |
| armed | output | 1 | Monitor is armed |
| waiting | output | 1 | Core is waiting on the line |
| watch_vaddr | output | ADDR_W | Stored watched virtual address |
| watch_line | output | ADDR_W | Stored physical line address |

## Verification
The snoop comparison is tried with an exact line hit, a hit on a different offset inside the same line, a different line, and a hit presented while unarmed or not waiting. Together these separate an exact-equality compare from a masked or flag-blind compare. Wait requests are tried both with and without a pending wakeup, so a sleep answer can be told apart from a consume answer. The same-cycle wait and snoop case tells the required wait-first ordering apart from comparing against the old line, and the wait that follows it shows whether the pending wakeup was left behind.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  typedef enum logic [1:0] {
    WR_NONE  = 2'd0,
    WR_SLEEP = 2'd1,
    WR_SKIP  = 2'd2
  } wait_res_e;

  function automatic int unsigned lwm_offw(input int unsigned line_bytes);
    return (line_bytes <= 1) ? 0 : $clog2(line_bytes);
  endfunction
endpackage

// File: rtl/lwm_align.sv
module lwm_align #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] line_out
);
  localparam int unsigned OFFW = lwm_pkg::lwm_offw(LINE_BYTES);

  generate
    if (OFFW == 0) begin : g_bytewise
      assign line_out = addr_in;
    end else begin : g_trim
      assign line_out = {addr_in[ADDR_W-1:OFFW], {OFFW{1'b0}}};
    end
  endgenerate
endmodule

// File: rtl/lwm_match.sv
module lwm_match #(
  parameter int unsigned ADDR_W = 48
) (
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_paddr,
  input  logic              armed_eff,
  input  logic              waiting_eff,
  input  logic [ADDR_W-1:0] line_eff,
  output logic              hit
);
  always_comb begin
    hit = snoop_valid && armed_eff && waiting_eff && (snoop_paddr == line_eff);
  end
endmodule

// File: rtl/lwm_ctrl.sv
module lwm_ctrl #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_valid,
  input  logic [ADDR_W-1:0] arm_vaddr,
  input  logic              wait_valid,
  input  logic [ADDR_W-1:0] wait_line,
  input  logic              hit,
  output logic              armed_eff,
  output logic              waiting_eff,
  output logic [ADDR_W-1:0] line_eff,
  output logic              armed_q,
  output logic              waiting_q,
  output logic [ADDR_W-1:0] vaddr_q,
  output logic [ADDR_W-1:0] line_q,
  output logic              wake_q,
  output logic              rsp_valid_q,
  output logic              rsp_sleep_q
);
  import lwm_pkg::*;
  localparam int unsigned OFFW = lwm_offw(LINE_BYTES);

  logic      pending_q;
  wait_res_e wres;
  logic [ADDR_W-1:0] line_arm;

  // Step 1: arm, step 2: wait, step 3 (in lwm_match): snoop compare.
  always_comb begin
    armed_eff   = armed_q | arm_valid;
    line_arm    = arm_valid ? '0 : line_q;
    line_eff    = line_arm;
    waiting_eff = waiting_q;
    wres        = WR_NONE;
    if (wait_valid) begin
      if (pending_q) begin
        wres = WR_SKIP;
      end else begin
        wres        = WR_SLEEP;
        line_eff    = wait_line;
        waiting_eff = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q     <= 1'b0;
      waiting_q   <= 1'b0;
      pending_q   <= 1'b0;
      vaddr_q     <= '0;
      line_q      <= '0;
      wake_q      <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_sleep_q <= 1'b0;
    end else begin
      armed_q     <= armed_eff;
      if (arm_valid) vaddr_q <= arm_vaddr;
      line_q      <= line_eff;
      waiting_q   <= waiting_eff & ~hit;
      wake_q      <= hit;
      pending_q   <= (pending_q & ~wait_valid) | (hit & wait_valid);
      rsp_valid_q <= (wres != WR_NONE);
      rsp_sleep_q <= (wres == WR_SLEEP);
    end
  end

  assert_sleep_rsp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_valid && !pending_q) |=> (rsp_valid_q && rsp_sleep_q));
  assert_skip_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_valid && pending_q) |=> (rsp_valid_q && !rsp_sleep_q));
  assert_arm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_valid && !wait_valid) |=> (armed_q && line_q == '0 && vaddr_q == $past(arm_vaddr)));
  assert_no_wake_unarmed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !arm_valid) |=> !wake_q);
  assert_wake_ends_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_q |-> (!waiting_q && armed_q));
  assert_armed_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !arm_valid) |=> (armed_q && $stable(vaddr_q)));
  generate
    if (OFFW > 0) begin : g_align_chk
      assert_line_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        waiting_q |-> (line_q[OFFW-1:0] == '0));
    end
  endgenerate
endmodule

// File: rtl/line_wake_monitor.sv
module line_wake_monitor #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned LINE_BYTES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_valid,
  input  logic [ADDR_W-1:0] arm_vaddr,
  input  logic              wait_valid,
  output logic              wait_ready,
  input  logic [ADDR_W-1:0] wait_paddr,
  output logic              rsp_valid,
  output logic              rsp_sleep,
  input  logic              snoop_valid,
  output logic              snoop_ready,
  input  logic [ADDR_W-1:0] snoop_paddr,
  output logic              wake,
  output logic              armed,
  output logic              waiting,
  output logic [ADDR_W-1:0] watch_vaddr,
  output logic [ADDR_W-1:0] watch_line
);
  logic [ADDR_W-1:0] wait_line, line_eff;
  logic armed_eff, waiting_eff, hit;

  assign wait_ready  = 1'b1;
  assign snoop_ready = 1'b1;

  lwm_align #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_align (
    .addr_in(wait_paddr), .line_out(wait_line));

  lwm_match #(.ADDR_W(ADDR_W)) u_match (
    .snoop_valid(snoop_valid), .snoop_paddr(snoop_paddr),
    .armed_eff(armed_eff), .waiting_eff(waiting_eff),
    .line_eff(line_eff), .hit(hit));

  lwm_ctrl #(.ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .arm_valid(arm_valid), .arm_vaddr(arm_vaddr),
    .wait_valid(wait_valid), .wait_line(wait_line), .hit(hit),
    .armed_eff(armed_eff), .waiting_eff(waiting_eff), .line_eff(line_eff),
    .armed_q(armed), .waiting_q(waiting), .vaddr_q(watch_vaddr),
    .line_q(watch_line), .wake_q(wake),
    .rsp_valid_q(rsp_valid), .rsp_sleep_q(rsp_sleep));

  assert_wake_one_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !wait_valid && !arm_valid) |=> !wake);
  assert_rsp_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_valid |=> !rsp_valid);
endmodule

// File: tb/tb_line_wake_monitor.sv
module tb_line_wake_monitor;
  localparam int AW = 48;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic arm_valid = 0, wait_valid = 0, snoop_valid = 0;
  logic [AW-1:0] arm_vaddr = '0, wait_paddr = '0, snoop_paddr = '0;
  logic wait_ready, snoop_ready, rsp_valid, rsp_sleep, wake, armed, waiting;
  logic [AW-1:0] watch_vaddr, watch_line;
  int checks = 0, failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  line_wake_monitor #(.ADDR_W(AW), .LINE_BYTES(64)) dut (
    .clk(clk), .rst_n(rst_n), .arm_valid(arm_valid), .arm_vaddr(arm_vaddr),
    .wait_valid(wait_valid), .wait_ready(wait_ready), .wait_paddr(wait_paddr),
    .rsp_valid(rsp_valid), .rsp_sleep(rsp_sleep), .snoop_valid(snoop_valid),
    .snoop_ready(snoop_ready), .snoop_paddr(snoop_paddr), .wake(wake),
    .armed(armed), .waiting(waiting), .watch_vaddr(watch_vaddr),
    .watch_line(watch_line));

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive one cycle of stimulus after a falling edge, sample after the next one
  task automatic step(input logic a, input logic [AW-1:0] av, input logic w,
                      input logic [AW-1:0] wp, input logic s, input logic [AW-1:0] sp);
    @(negedge clk);
    arm_valid = a; arm_vaddr = av; wait_valid = w; wait_paddr = wp;
    snoop_valid = s; snoop_paddr = sp;
    @(negedge clk);
    arm_valid = 0; wait_valid = 0; snoop_valid = 0;
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1", "armed", armed, 0);
    chk("R1", "waiting", waiting, 0);
    chk("R1", "wake", wake, 0);
    chk("R1", "rsp_valid", rsp_valid, 0);
    step(0, 0, 1, 48'h1000, 0, 0);
    chk("R1", "no pending after reset -> sleep", rsp_sleep, 1);
  endtask

  task automatic t_arm;
    do_reset();
    step(0, 0, 1, 48'h2040, 0, 0);
    step(1, 48'hABCD_1234_5678, 0, 0, 0, 0);
    chk("R2", "armed", armed, 1);
    chk("R2", "watch_vaddr", watch_vaddr, 48'hABCD_1234_5678);
    chk("R2", "watch_line cleared", watch_line, 0);
  endtask

  task automatic t_wait_sleep;
    do_reset();
    step(1, 48'h55, 0, 0, 0, 0);
    chk("R3", "ready wait", wait_ready, 1);
    chk("R3", "ready snoop", snoop_ready, 1);
    step(0, 0, 1, 48'h1234_5678_9ABF, 0, 0);
    chk("R3", "rsp_valid", rsp_valid, 1);
    chk("R3", "rsp_sleep", rsp_sleep, 1);
    chk("R3", "waiting", waiting, 1);
    chk("R3", "watch_line aligned", watch_line, 48'h1234_5678_9A80);
  endtask

  task automatic t_snoop_wake;
    do_reset();
    step(1, 48'h77, 0, 0, 0, 0);
    step(0, 0, 1, 48'h3000_0010, 0, 0);
    step(0, 0, 0, 0, 1, 48'h3000_0000);
    chk("R5", "wake pulse", wake, 1);
    chk("R5", "waiting cleared", waiting, 0);
    chk("R8", "armed kept", armed, 1);
    chk("R8", "vaddr kept", watch_vaddr, 48'h77);
    @(negedge clk);
    chk("R5", "wake one cycle", wake, 0);
    step(0, 0, 1, 48'h3000_0000, 0, 0);
    chk("R5", "no pending left -> sleep", rsp_sleep, 1);
  endtask

  task automatic t_no_wake;
    do_reset();
    step(0, 0, 1, 48'h4000, 0, 0);
    step(0, 0, 0, 0, 1, 48'h4000);
    chk("R6", "unarmed no wake", wake, 0);
    chk("R6", "unarmed still waiting", waiting, 1);
    step(1, 48'h9, 0, 0, 0, 0);
    step(0, 0, 1, 48'h5000, 0, 0);
    step(0, 0, 0, 0, 1, 48'h5005);
    chk("R6", "in-line offset no wake", wake, 0);
    step(0, 0, 0, 0, 1, 48'h5040);
    chk("R6", "other line no wake", wake, 0);
    chk("R6", "still waiting", waiting, 1);
    step(0, 0, 0, 0, 1, 48'h5000);
    chk("R5", "exact hit wakes", wake, 1);
    step(0, 0, 0, 0, 1, 48'h5000);
    chk("R6", "not waiting no wake", wake, 0);
  endtask

  task automatic t_same_cycle;
    do_reset();
    step(1, 48'h11, 0, 0, 0, 0);
    step(0, 0, 1, 48'h6000_0020, 1, 48'h6000_0000);
    chk("R7", "sleep rsp", rsp_sleep, 1);
    chk("R7", "wake vs new line", wake, 1);
    chk("R7", "waiting cleared", waiting, 0);
    step(0, 0, 1, 48'h6000_0000, 0, 0);
    chk("R4", "rsp_valid", rsp_valid, 1);
    chk("R4", "pending consumed -> no sleep", rsp_sleep, 0);
    chk("R4", "waiting not set", waiting, 0);
    step(0, 0, 1, 48'h6000_0000, 0, 0);
    chk("R4", "pending cleared -> sleep", rsp_sleep, 1);
  endtask

  initial begin
    t_reset();
    t_arm();
    t_wait_sleep();
    t_snoop_wake();
    t_no_wake();
    t_same_cycle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule